// File: doc/BRIEF.md
# Packet FIFO Occupancy and Bus-Request Controller

This block manages a 16-byte packet buffer that sits between a bit-serial network side and a local DMA engine. On receive the network side pushes bytes and the DMA drains them; on transmit the DMA fills the buffer and the network side pulls bytes. The block keeps the occupancy count, raises a bus request when a programmable threshold is reached and flags overrun and underrun. The DMA side moves single bytes or 16-bit words, with the low byte first.

Receive bursts need a small margin. In byte mode a request starts one byte past the threshold, and in word mode it starts two bytes past it. The first burst of a receive frame waits until eight bytes have arrived, so that the destination address can be judged before any byte leaves. A rejected packet is dropped through the same single-cycle flush input that clears the buffer for any other reason.

Top module: `fifo_thresh_ctrl`

## Requirements
- R1: After reset, and one cycle after `flush` is high, `level` is 0 and `bus_req`, `overrun` and `underrun` are 0.
- R2: `thr_sel` selects the threshold in bytes: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 12. In receive byte mode (`dir_rx`=1, `word_mode`=0), `bus_req` rises on the clock edge that raises `level` to the threshold plus 1.
- R3: In receive word mode, `bus_req` rises on the edge that raises `level` to the threshold plus 2. A DMA word read returns the older byte in bits 7:0 and the next byte in bits 15:8, and it removes two bytes.
- R4: After a frame starts (`frame_open` rises) or after a flush, the first receive request does not rise before `level` reaches 8. Later bursts in the same frame use only the threshold rule.
- R5: On receive, `overrun` is set on the edge where a write raises `level` to 13 or more. It then stays set until a flush.
- R6: On transmit (`dir_rx`=0), `bus_req` is raised while `frame_open` is high and the free space (16 minus `level`) is at least the threshold.
- R7: On transmit, a network read while `level` is 0 and `frame_open` is high sets `underrun`, which stays set until a flush. A read on an empty buffer never changes `level`.
- R8: `bus_req` falls on the edge where the bytes moved by the DMA since the request rose reach the threshold.
- R9: On receive, once `frame_open` is low, `bus_req` rises while at least one transfer unit (1 byte, or 2 in word mode) remains. It falls on the edge where fewer than one unit is left.
- R10: A network write and a DMA read in the same receive cycle are both applied: `level` does not change and byte order is kept.
- R11: Strobes for the other direction are ignored. On receive, `net_rd` and `dma_wr` leave `level` unchanged; on transmit, `net_wr` and `dma_rd` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear; also used to drop a rejected packet |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| word_mode | input | 1 | 1 = DMA moves 16-bit words |
| thr_sel | input | 2 | Threshold select (2/4/8/12 bytes) |
| frame_open | input | 1 | High while a frame is in progress |
| net_wr | input | 1 | Network side byte write (receive) |
| net_wdata | input | 8 | Network write byte |
| net_rd | input | 1 | Network side byte read (transmit) |
| net_rdata | output | 8 | Oldest byte in the buffer |
| dma_wr | input | 1 | DMA write (transmit) |
| dma_wdata | input | 16 | DMA write data, low byte first |
| dma_rd | input | 1 | DMA read (receive) |
| dma_rdata | output | 16 | DMA read data |
| bus_req | output | 1 | Bus request to the DMA |
| overrun | output | 1 | Sticky receive overrun flag |
| underrun | output | 1 | Sticky transmit underrun flag |
| level | output | 5 | Bytes currently held |

## Verification
A network write and a DMA read can fall in the same receive cycle. The occupancy must then net to zero and the read pointer must still return bytes in arrival order. The bench provokes this by pulsing `net_wr` and `dma_rd` together on a partly filled buffer. It then judges the unchanged `level` and checks that the next DMA read returns the byte that followed the one just removed. A second overlap happens when the edge that ends one burst immediately allows the next request. This is judged by seeing `bus_req` low for exactly one cycle and then high again.

// File: rtl/fifo_thresh_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the packet FIFO controller.
// Assumes thr_sel is a 2-bit code.
package fifo_thresh_pkg;

    // Map the 2-bit threshold select to a byte count.
    function automatic int unsigned thr_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
// Byte storage with circular read and write pointers.
// Moves 0, 1 or 2 bytes per side per cycle. A 2-byte write places bits
// 7:0 first. Assumes DEPTH is a power of two and that the caller only
// asks for moves that fit (the occupancy block gates them).
module fifo_store #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    wr_n,
    input  logic [15:0]   wdata,
    input  logic [1:0]    rd_n,
    output logic [7:0]    rd_b0,
    output logic [7:0]    rd_b1,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr
);
    logic [7:0] mem [DEPTH];

    // Store the accepted bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_n != 2'd0) mem[wptr] <= wdata[7:0];
        if (wr_n == 2'd2) mem[wptr + PW'(1)] <= wdata[15:8];
    end

    // Advance the pointers by the number of bytes moved.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            wptr <= wptr + PW'(wr_n);
            rptr <= rptr + PW'(rd_n);
        end
    end

    // Present the two oldest bytes.
    always_comb begin
        rd_b0 = mem[rptr];
        rd_b1 = mem[rptr + PW'(1)];
    end
endmodule

// File: rtl/fifo_occupancy.sv
`timescale 1ns/1ps
// Occupancy counter and error flags.
// Decides which strobes are accepted for the current direction, produces
// next-cycle occupancy and keeps sticky overrun/underrun flags.
// Assumes at most one write side and one read side act per cycle.
module fifo_occupancy #(
    parameter int DEPTH     = 16,
    parameter int OVR_LEVEL = 13,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dir_rx,
    input  logic          word_mode,
    input  logic          frame_open,
    input  logic          net_wr,
    input  logic          net_rd,
    input  logic          dma_wr,
    input  logic          dma_rd,
    output logic [1:0]    wr_n,
    output logic [1:0]    rd_n,
    output logic [CW-1:0] dma_n,
    output logic [CW-1:0] count,
    output logic [CW-1:0] cnt_nxt,
    output logic          overrun,
    output logic          underrun
);
    logic [CW-1:0] unit_w;
    logic [CW-1:0] free_w;
    logic          starve;

    // Accept strobes that fit and form the next occupancy.
    always_comb begin
        unit_w = word_mode ? CW'(2) : CW'(1);
        free_w = CW'(DEPTH) - count;
        wr_n   = 2'd0;
        rd_n   = 2'd0;
        if (dir_rx) begin
            if (net_wr && free_w != '0) wr_n = 2'd1;
            if (dma_rd && count >= unit_w) rd_n = unit_w[1:0];
        end else begin
            if (dma_wr && free_w >= unit_w) wr_n = unit_w[1:0];
            if (net_rd && count != '0) rd_n = 2'd1;
        end
        dma_n   = dir_rx ? CW'(rd_n) : CW'(wr_n);
        cnt_nxt = count + CW'(wr_n) - CW'(rd_n);
        starve  = !dir_rx && net_rd && (count == '0) && frame_open;
    end

    // Register occupancy and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            count <= cnt_nxt;
            if (dir_rx && wr_n != 2'd0 && cnt_nxt >= CW'(OVR_LEVEL)) overrun <= 1'b1;
            if (starve) underrun <= 1'b1;
        end
    end

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);
    assert_unr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !flush) |=> underrun);
    assert_empty_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && net_rd && count == '0 && !dma_wr && !flush) |=> (count == '0));
endmodule

// File: rtl/fifo_req_ctrl.sv
`timescale 1ns/1ps
// Bus-request sequencer.
// Raises the request from next-cycle occupancy, counts DMA bytes in the
// burst, and gates the first receive burst of a frame until GATE bytes
// are held. Assumes dma_n only counts accepted DMA transfers.
module fifo_req_ctrl #(
    parameter int DEPTH = 16,
    parameter int GATE  = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dir_rx,
    input  logic          word_mode,
    input  logic [1:0]    thr_sel,
    input  logic          frame_open,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] dma_n,
    output logic          breq
);
    import fifo_thresh_pkg::*;

    logic [CW-1:0] thr, unit_w, rx_lvl, room_nxt, moved, moved_sum;
    logic          first_done, fo_q, start_c, stop_c;

    // Work out the start and stop conditions for this cycle.
    always_comb begin
        thr       = CW'(thr_bytes(thr_sel));
        unit_w    = word_mode ? CW'(2) : CW'(1);
        rx_lvl    = thr + unit_w;
        room_nxt  = CW'(DEPTH) - cnt_nxt;
        moved_sum = moved + dma_n;
        if (dir_rx) begin
            start_c = ((cnt_nxt >= rx_lvl) && (first_done || cnt_nxt >= CW'(GATE)))
                    || (!frame_open && cnt_nxt >= unit_w);
            stop_c  = (moved_sum >= thr) || (!frame_open && cnt_nxt < unit_w);
        end else begin
            start_c = frame_open && (room_nxt >= thr);
            stop_c  = (moved_sum >= thr) || !frame_open;
        end
    end

    // Request state, burst byte count and first-burst gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            breq       <= 1'b0;
            moved      <= '0;
            first_done <= 1'b0;
            fo_q       <= 1'b0;
        end else if (flush) begin
            breq       <= 1'b0;
            moved      <= '0;
            first_done <= 1'b0;
            fo_q       <= frame_open;
        end else begin
            fo_q <= frame_open;
            if (breq) begin
                if (stop_c) begin
                    breq  <= 1'b0;
                    moved <= '0;
                end else begin
                    moved <= moved_sum;
                end
            end else if (start_c) begin
                breq       <= 1'b1;
                moved      <= '0;
                first_done <= 1'b1;
            end
            if (frame_open && !fo_q) first_done <= 1'b0;
        end
    end

    assert_burst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        breq |-> (moved < thr));
    assert_rx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!breq && dir_rx && frame_open && fo_q && !first_done && !flush)
        |=> (!breq || $past(cnt_nxt) >= CW'(GATE)));
endmodule

// File: rtl/fifo_thresh_ctrl.sv
`timescale 1ns/1ps
// Top of the packet FIFO threshold controller.
// Connects storage, occupancy and request logic and steers the data path
// by direction. Assumes dma_wdata carries the older byte in bits 7:0.
module fifo_thresh_ctrl #(
    parameter int DEPTH     = 16,
    parameter int OVR_LEVEL = 13,
    parameter int RX_GATE   = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dir_rx,
    input  logic          word_mode,
    input  logic [1:0]    thr_sel,
    input  logic          frame_open,
    input  logic          net_wr,
    input  logic [7:0]    net_wdata,
    input  logic          net_rd,
    output logic [7:0]    net_rdata,
    input  logic          dma_wr,
    input  logic [15:0]   dma_wdata,
    input  logic          dma_rd,
    output logic [15:0]   dma_rdata,
    output logic          bus_req,
    output logic          overrun,
    output logic          underrun,
    output logic [CW-1:0] level
);
    logic [1:0]    wr_n, rd_n;
    logic [CW-1:0] dma_n, cnt_nxt;
    logic [15:0]   wdata;
    logic [7:0]    rd_b0, rd_b1;
    logic [PW-1:0] wptr, rptr;

    // Pick the write source for the active direction.
    always_comb wdata = dir_rx ? {8'h00, net_wdata} : dma_wdata;

    fifo_occupancy #(.DEPTH(DEPTH), .OVR_LEVEL(OVR_LEVEL)) u_occ (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_rx(dir_rx),
        .word_mode(word_mode), .frame_open(frame_open),
        .net_wr(net_wr), .net_rd(net_rd), .dma_wr(dma_wr), .dma_rd(dma_rd),
        .wr_n(wr_n), .rd_n(rd_n), .dma_n(dma_n), .count(level),
        .cnt_nxt(cnt_nxt), .overrun(overrun), .underrun(underrun)
    );

    fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_n(wr_n), .wdata(wdata),
        .rd_n(rd_n), .rd_b0(rd_b0), .rd_b1(rd_b1), .wptr(wptr), .rptr(rptr)
    );

    fifo_req_ctrl #(.DEPTH(DEPTH), .GATE(RX_GATE)) u_req (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_rx(dir_rx),
        .word_mode(word_mode), .thr_sel(thr_sel), .frame_open(frame_open),
        .cnt_nxt(cnt_nxt), .dma_n(dma_n), .breq(bus_req)
    );

    // Form the read data for both sides.
    always_comb begin
        net_rdata = rd_b0;
        dma_rdata = word_mode ? {rd_b1, rd_b0} : {8'h00, rd_b0};
    end

    assert_ptr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) == level[PW-1:0]);
    assert_flush_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !bus_req && !overrun && !underrun));
endmodule

// File: tb/fifo_thresh_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_thresh_ctrl_bench;
    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, dir_rx = 1'b1, word_mode = 1'b0;
    logic [1:0] thr_sel = 2'd2;
    logic frame_open = 1'b0, net_wr = 1'b0, net_rd = 1'b0, dma_wr = 1'b0, dma_rd = 1'b0;
    logic [7:0] net_wdata = 8'h00, net_rdata;
    logic [15:0] dma_wdata = 16'h0000, dma_rdata;
    logic bus_req, overrun, underrun;
    logic [4:0] level;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fifo_thresh_ctrl u_fifo_thresh_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_rx(dir_rx),
        .word_mode(word_mode), .thr_sel(thr_sel), .frame_open(frame_open),
        .net_wr(net_wr), .net_wdata(net_wdata), .net_rd(net_rd), .net_rdata(net_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
        .bus_req(bus_req), .overrun(overrun), .underrun(underrun), .level(level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic do_flush();
        flush = 1'b1; cyc(); flush = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        net_wr = 1'b1; net_wdata = b; cyc(); net_wr = 1'b0;
    endtask

    task automatic pull_dma();
        dma_rd = 1'b1; cyc(); dma_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset level", level, 0);
        chk("R1 reset bus_req", bus_req, 0);
        chk("R1 reset flags", {overrun, underrun}, 0);
    endtask

    task automatic t_rx_byte();
        dir_rx = 1; word_mode = 0; thr_sel = 2; frame_open = 1; do_flush();
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
        chk("R2 no req at 8", bus_req, 0);
        push(8'h18);
        chk("R2 req at 9", bus_req, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R2 byte order", dma_rdata, 16'h0010 + i);
            pull_dma();
            if (i == 6) chk("R8 req held", bus_req, 1);
        end
        chk("R8 req drops after 8", bus_req, 0);
        chk("R8 level", level, 1);
        do_flush();
        chk("R1 flush level", level, 0);
    endtask

    task automatic t_gate();
        dir_rx = 1; word_mode = 0; thr_sel = 0; do_flush();
        for (int i = 0; i < 7; i++) push(8'(i));
        chk("R4 gated at 7", bus_req, 0);
        push(8'h07);
        chk("R4 req at 8", bus_req, 1);
        pull_dma(); pull_dma();
        chk("R8 drop after 2", bus_req, 0);
        cyc();
        chk("R4 later burst", bus_req, 1);
    endtask

    task automatic t_word();
        dir_rx = 1; word_mode = 1; thr_sel = 2; do_flush();
        for (int i = 0; i < 9; i++) push(8'h20 + 8'(i));
        chk("R3 no req at 9", bus_req, 0);
        push(8'h29);
        chk("R3 req at 10", bus_req, 1);
        chk("R3 word data", dma_rdata, 16'h2120);
        for (int i = 0; i < 4; i++) pull_dma();
        chk("R8 word drop", bus_req, 0);
        chk("R3 word level", level, 2);
        word_mode = 0;
    endtask

    task automatic t_ovr();
        dir_rx = 1; thr_sel = 3; do_flush();
        for (int i = 0; i < 12; i++) push(8'(i));
        chk("R5 no ovr at 12", overrun, 0);
        push(8'h0c);
        chk("R5 ovr at 13", overrun, 1);
        chk("R2 thr12 req at 13", bus_req, 1);
        push(8'h0d);
        chk("R5 ovr sticky", overrun, 1);
        do_flush();
        chk("R1 flush clears ovr", overrun, 0);
    endtask

    task automatic t_simul();
        dir_rx = 1; thr_sel = 3; do_flush();
        for (int i = 0; i < 5; i++) push(8'h40 + 8'(i));
        chk("R10 head", dma_rdata, 16'h0040);
        net_wr = 1; net_wdata = 8'h45; dma_rd = 1; cyc(); net_wr = 0; dma_rd = 0;
        chk("R10 level kept", level, 5);
        chk("R10 order", dma_rdata, 16'h0041);
        dma_wr = 1; dma_wdata = 16'hffff; cyc(); dma_wr = 0;
        chk("R11 rx dma_wr ignored", level, 5);
        net_rd = 1; cyc(); net_rd = 0;
        chk("R11 rx net_rd ignored", level, 5);
    endtask

    task automatic t_drain();
        dir_rx = 1; thr_sel = 2; frame_open = 1; do_flush();
        for (int i = 0; i < 3; i++) push(8'(i));
        chk("R9 no req mid frame", bus_req, 0);
        frame_open = 0; cyc();
        chk("R9 drain req", bus_req, 1);
        for (int i = 0; i < 3; i++) pull_dma();
        chk("R9 drain drop", bus_req, 0);
        chk("R9 drained", level, 0);
    endtask

    task automatic t_tx();
        dir_rx = 0; word_mode = 1; thr_sel = 2; frame_open = 0; do_flush();
        cyc();
        chk("R6 no req outside frame", bus_req, 0);
        frame_open = 1; cyc();
        chk("R6 req with room", bus_req, 1);
        for (int i = 0; i < 4; i++) begin
            dma_wr = 1; dma_wdata = {8'h51 + 8'(2*i), 8'h50 + 8'(2*i)}; cyc(); dma_wr = 0;
        end
        chk("R8 tx drop", bus_req, 0);
        chk("R6 level 8", level, 8);
        cyc();
        chk("R6 req again", bus_req, 1);
        for (int i = 0; i < 4; i++) begin
            dma_wr = 1; dma_wdata = 16'h6060; cyc(); dma_wr = 0;
        end
        cyc();
        chk("R6 full no req", bus_req, 0);
        chk("R6 full level", level, 16);
        net_wr = 1; net_wdata = 8'h99; cyc(); net_wr = 0;
        chk("R11 tx net_wr ignored", level, 16);
        dma_rd = 1; cyc(); dma_rd = 0;
        chk("R11 tx dma_rd ignored", level, 16);
        chk("R6 tx head", net_rdata, 8'h50);
        net_rd = 1; cyc(); net_rd = 0;
        chk("R6 tx read", level, 15);
        chk("R3 tx high byte", net_rdata, 8'h51);
        word_mode = 0;
    endtask

    task automatic t_unr();
        dir_rx = 0; frame_open = 1; do_flush();
        net_rd = 1; cyc(); net_rd = 0;
        chk("R7 underrun set", underrun, 1);
        chk("R7 level stays 0", level, 0);
        frame_open = 0; do_flush();
        net_rd = 1; cyc(); net_rd = 0;
        chk("R7 no underrun outside frame", underrun, 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_rx_byte();
        t_gate();
        t_word();
        t_ovr();
        t_simul();
        t_drain();
        t_tx();
        t_unr();
        done = 1'b1;
        report();
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end
endmodule